// File: doc/BRIEF.md
# System Management Interrupt Arbiter

This block drives an active-low system management interrupt line towards a processor. Three kinds of event feed it: a legacy USB event input, a software "release" write that stands for a BIOS hand-off request, and a vector of generic event inputs. Each event latches a sticky status bit. Software clears a status bit by writing a 1 to it. A status bit becomes a request when its own enable bit is set, and the global enable gates every request.

The arbiter pulls the line low for one enabled, pending request and then holds it low until software has serviced the request and writes the end-of-service bit. Hardware clears that bit when it drives the line low. After the write, the line stays high for a fixed gap before the next assertion is allowed. The first interrupt after reset does not need the end-of-service bit. Every later interrupt does.

Top module: `smi_arbiter`

## Requirements
- R1: After reset, `smi_n_o` is 1, the control word reads 0, and the status word and the generic enable word read 0.
- R2: While the global enable (control bit 0) is 0, `smi_n_o` never goes from high to low.
- R3: After each reset, the first enabled pending request drives `smi_n_o` low even though the end-of-service bit is 0. The line goes low on the second rising edge after the event is sampled.
- R4: Once low, `smi_n_o` stays low until a write to the control word has bit 1 set. From that edge on, the line is high for exactly `GAP_CLKS` cycles. If an enabled request is still pending, the line then goes low again.
- R5: The end-of-service bit (control bit 1) reads 0 from the edge that drives `smi_n_o` low.
- R6: Apart from the first interrupt after reset, an assertion happens only when the end-of-service bit is 1 and an enabled status bit is pending. With no such request the line stays high after the gap.
- R7: A high level on `usb_evt_i` sets status bit 0. That bit raises a request only while control bit 3 is 1.
- R8: A write to address 3 with data bit 0 set sets status bit 1. That bit raises a request only while control bit 2 is 1.
- R9: Generic event input k sets status bit 2+k. It raises a request only while bit k of the generic enable word at address 2 is 1. That word reads back as written.
- R10: A write to the status word at address 1 clears every bit written as 1. A bit whose event is active in the same cycle stays set.
- R11: The control word at address 0 holds global enable in bit 0, end-of-service in bit 1, release enable in bit 2 and USB enable in bit 3. All four bits read back their current values.
- R12: A reset in mid-operation returns every register to its reset value and restores the first-interrupt exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 status, 2 generic enable, 3 release) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address, same map as writes. Address 3 reads 0 |
| rd_data | output | DATA_W | Combinational read data |
| usb_evt_i | input | 1 | Legacy USB event, level sampled each clock |
| gen_evt_i | input | N_GEN | Generic event inputs, level sampled each clock |
| smi_n_o | output | 1 | Active-low system management interrupt |

## Verification
The bench builds the block with `N_GEN = 3`, `GAP_CLKS = 4` and `DATA_W = 8`. Three generic bits keep the status word and its enable within one byte that the bench can write as a literal. They still leave room to enable one generic source while an unenabled one is pending. The four-cycle gap is short, so the table can count every high cycle between an end-of-service write and the next assertion. It also shows the line returning to idle when nothing enabled is pending once the gap expires.

// File: rtl/smi_arb_pkg.sv
package smi_arb_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL   = 2'd0,
      REG_STS    = 2'd1,
      REG_GEN_EN = 2'd2,
      REG_RLS    = 2'd3
   } reg_sel_e;

   // control word bit positions
   localparam int CTL_GBL  = 0;
   localparam int CTL_EOS  = 1;
   localparam int CTL_RLS  = 2;
   localparam int CTL_USB  = 3;
   localparam int CTL_W    = 4;

   // status word bit positions
   localparam int STS_USB  = 0;
   localparam int STS_RLS  = 1;
   localparam int STS_GEN0 = 2;

   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_LOW  = 2'd1,
      ARB_GAP  = 2'd2
   } arb_state_e;

endpackage

// File: rtl/smi_ctrl_regs.sv
module smi_ctrl_regs
   import smi_arb_pkg::*;
#(
   parameter int N_GEN  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fire,
   output logic              gbl_en,
   output logic              eos_q,
   output logic              rls_en,
   output logic              usb_en,
   output logic [N_GEN-1:0]  gen_en,
   output logic              eos_wr,
   output logic              rls_wr
);

   logic wr_ctrl, wr_gen;

   assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
   assign wr_gen  = wr_en && (wr_addr == REG_GEN_EN);
   assign eos_wr  = wr_ctrl && wr_data[CTL_EOS];
   assign rls_wr  = wr_en && (wr_addr == REG_RLS) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gbl_en <= 1'b0;
         rls_en <= 1'b0;
         usb_en <= 1'b0;
         gen_en <= '0;
      end else begin
         if (wr_ctrl) begin
            gbl_en <= wr_data[CTL_GBL];
            rls_en <= wr_data[CTL_RLS];
            usb_en <= wr_data[CTL_USB];
         end
         if (wr_gen) begin
            gen_en <= wr_data[N_GEN-1:0];
         end
      end
   end

   // hardware clear on assertion takes precedence over a software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eos_q <= 1'b0;
      end else if (fire) begin
         eos_q <= 1'b0;
      end else if (wr_ctrl) begin
         eos_q <= wr_data[CTL_EOS];
      end
   end

endmodule

// File: rtl/smi_status.sv
module smi_status #(
   parameter int NSRC = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_vec,
   input  logic [NSRC-1:0] clr_vec,
   output logic [NSRC-1:0] sts
);

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sts[i] <= 1'b0;
         end else if (set_vec[i]) begin
            sts[i] <= 1'b1;
         end else if (clr_vec[i]) begin
            sts[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/smi_gate_fsm.sv
module smi_gate_fsm
   import smi_arb_pkg::*;
#(
   parameter int GAP_CLKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic eos_q,
   input  logic eos_wr,
   output logic fire,
   output logic smi_n
);

   arb_state_e state_q, state_d;
   logic       first_q;
   logic       can_go;
   logic       gap_done;
   logic       gap_load;

   assign can_go   = pending && (first_q || eos_q);
   assign gap_load = (state_q == ARB_LOW) && eos_wr;

   if (GAP_CLKS > 1) begin : g_gap_cnt
      localparam int CNT_W = $clog2(GAP_CLKS);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (gap_load) begin
            cnt_q <= CNT_W'(GAP_CLKS - 1);
         end else if ((state_q == ARB_GAP) && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign gap_done = (cnt_q == '0);
   end else begin : g_gap_one
      assign gap_done = 1'b1;
   end

   always_comb begin
      state_d = state_q;
      fire    = 1'b0;
      unique case (state_q)
         ARB_IDLE: begin
            if (can_go) begin
               state_d = ARB_LOW;
               fire    = 1'b1;
            end
         end
         ARB_LOW: begin
            if (eos_wr) state_d = ARB_GAP;
         end
         ARB_GAP: begin
            if (gap_done) begin
               if (can_go) begin
                  state_d = ARB_LOW;
                  fire    = 1'b1;
               end else begin
                  state_d = ARB_IDLE;
               end
            end
         end
         default: state_d = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         first_q <= 1'b1;
      end else begin
         state_q <= state_d;
         if (fire) first_q <= 1'b0;
      end
   end

   assign smi_n = (state_q != ARB_LOW);

endmodule

// File: rtl/smi_arbiter.sv
module smi_arbiter
   import smi_arb_pkg::*;
#(
   parameter int N_GEN    = 4,
   parameter int GAP_CLKS = 4,
   parameter int DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              usb_evt_i,
   input  logic [N_GEN-1:0]  gen_evt_i,
   output logic              smi_n_o
);

   localparam int NSRC = N_GEN + 2;

   if (N_GEN < 1) begin : g_bad_ngen
      $error("smi_arbiter: N_GEN must be at least 1");
   end
   if (DATA_W < NSRC || DATA_W < CTL_W) begin : g_bad_width
      $error("smi_arbiter: DATA_W too narrow for status or control word");
   end
   if (GAP_CLKS < 1) begin : g_bad_gap
      $error("smi_arbiter: GAP_CLKS must be at least 1");
   end

   logic             gbl_en, eos_q, rls_en, usb_en;
   logic [N_GEN-1:0] gen_en;
   logic             eos_wr, rls_wr;
   logic             fire;
   logic             pending;
   logic [NSRC-1:0]  sts, set_vec, clr_vec, en_vec;

   smi_ctrl_regs #(.N_GEN(N_GEN), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .fire    (fire),
      .gbl_en  (gbl_en),
      .eos_q   (eos_q),
      .rls_en  (rls_en),
      .usb_en  (usb_en),
      .gen_en  (gen_en),
      .eos_wr  (eos_wr),
      .rls_wr  (rls_wr)
   );

   assign set_vec = {gen_evt_i, rls_wr, usb_evt_i};
   assign clr_vec = (wr_en && (wr_addr == REG_STS)) ? wr_data[NSRC-1:0] : '0;
   assign en_vec  = {gen_en, rls_en, usb_en};

   smi_status #(.NSRC(NSRC)) u_sts (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .sts     (sts)
   );

   assign pending = gbl_en && (|(sts & en_vec));

   smi_gate_fsm #(.GAP_CLKS(GAP_CLKS)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (pending),
      .eos_q   (eos_q),
      .eos_wr  (eos_wr),
      .fire    (fire),
      .smi_n   (smi_n_o)
   );

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         REG_CTRL: begin
            rd_data[CTL_GBL] = gbl_en;
            rd_data[CTL_EOS] = eos_q;
            rd_data[CTL_RLS] = rls_en;
            rd_data[CTL_USB] = usb_en;
         end
         REG_STS:    rd_data[NSRC-1:0]  = sts;
         REG_GEN_EN: rd_data[N_GEN-1:0] = gen_en;
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/smi_arbiter_chk.sv
module smi_arbiter_chk #(
   parameter int GAP_CLKS = 4
) (
   input logic clk,
   input logic rst_n,
   input logic smi_n_o,
   input logic gbl_en,
   input logic eos_q,
   input logic eos_wr
);

   localparam int HW = $clog2(GAP_CLKS + 1) + 1;

   logic [HW-1:0] hi_cnt;
   logic          had_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt  <= '0;
         had_low <= 1'b0;
      end else begin
         if (!smi_n_o) begin
            hi_cnt  <= '0;
            had_low <= 1'b1;
         end else if (32'(hi_cnt) < GAP_CLKS) begin
            hi_cnt <= hi_cnt + 1'b1;
         end
      end
   end

   // R2
   gbl_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smi_n_o && !gbl_en) |=> smi_n_o);

   // R5
   eos_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(smi_n_o) |-> !eos_q);

   // R4
   low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!smi_n_o && !eos_wr) |=> !smi_n_o);

   // R4
   gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (had_low && smi_n_o && (32'(hi_cnt) + 1 < GAP_CLKS)) |=> smi_n_o);

   // R6
   reassert_eos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(smi_n_o) && had_low) |-> $past(eos_q));

endmodule

bind smi_arbiter smi_arbiter_chk #(.GAP_CLKS(GAP_CLKS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .smi_n_o (smi_n_o),
   .gbl_en  (gbl_en),
   .eos_q   (eos_q),
   .eos_wr  (eos_wr)
);

// File: tb/tb_smi_arbiter.sv
module tb_smi_arbiter;

   localparam int N_GEN    = 3;
   localparam int GAP_CLKS = 4;
   localparam int DATA_W   = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [1:0]        rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              usb_evt_i = 1'b0;
   logic [N_GEN-1:0]  gen_evt_i = '0;
   logic              smi_n_o;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2ns clk = ~clk;

   smi_arbiter #(.N_GEN(N_GEN), .GAP_CLKS(GAP_CLKS), .DATA_W(DATA_W)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .usb_evt_i (usb_evt_i),
      .gen_evt_i (gen_evt_i),
      .smi_n_o   (smi_n_o)
   );

   typedef struct packed {
      logic [3:0] req;
      logic       wr;
      logic [1:0] wa;
      logic [7:0] wd;
      logic       usb;
      logic [2:0] gen;
      logic       smi;
      logic [3:0] ctl;
   } vec_t;

   // each row: inputs for one clock, then smi_n_o and control word after that edge
   localparam vec_t TBL [38] = '{
      '{4'd11, 1'b1, 2'd0, 8'h08, 1'b0, 3'd0, 1'b1, 4'h8}, // R11 usb enable only
      '{4'd7,  1'b0, 2'd0, 8'h00, 1'b1, 3'd0, 1'b1, 4'h8}, // R7 usb event
      '{4'd2,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'h8}, // R2 global off
      '{4'd2,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'h8},
      '{4'd11, 1'b1, 2'd0, 8'h09, 1'b0, 3'd0, 1'b1, 4'h9}, // R11 global on
      '{4'd3,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 4'h9}, // R3 first without eos
      '{4'd4,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 4'h9}, // R4 holds low
      '{4'd10, 1'b1, 2'd1, 8'h01, 1'b0, 3'd0, 1'b0, 4'h9}, // R10 clear usb
      '{4'd4,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 4'h9},
      '{4'd4,  1'b1, 2'd0, 8'h0B, 1'b0, 3'd0, 1'b1, 4'hB}, // R4 eos write, gap 1
      '{4'd4,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'hB}, // gap 2
      '{4'd7,  1'b0, 2'd0, 8'h00, 1'b1, 3'd0, 1'b1, 4'hB}, // R7 gap 3, event
      '{4'd4,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'hB}, // gap 4
      '{4'd5,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 4'h9}, // R5 eos cleared on assert
      '{4'd11, 1'b1, 2'd0, 8'h09, 1'b0, 3'd0, 1'b0, 4'h9},
      '{4'd10, 1'b1, 2'd1, 8'h01, 1'b0, 3'd0, 1'b0, 4'h9},
      '{4'd9,  1'b0, 2'd0, 8'h00, 1'b0, 3'd1, 1'b0, 4'h9}, // R9 gen0, not enabled
      '{4'd4,  1'b1, 2'd0, 8'h0B, 1'b0, 3'd0, 1'b1, 4'hB},
      '{4'd9,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'hB},
      '{4'd9,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'hB},
      '{4'd9,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'hB},
      '{4'd6,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'hB}, // R6 idle, nothing enabled
      '{4'd9,  1'b1, 2'd2, 8'h01, 1'b0, 3'd0, 1'b1, 4'hB}, // R9 enable gen0
      '{4'd6,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 4'h9}, // R6 asserts with eos
      '{4'd10, 1'b1, 2'd1, 8'h04, 1'b0, 3'd0, 1'b0, 4'h9},
      '{4'd8,  1'b1, 2'd3, 8'h01, 1'b0, 3'd0, 1'b0, 4'h9}, // R8 release, not enabled
      '{4'd4,  1'b1, 2'd0, 8'h0F, 1'b0, 3'd0, 1'b1, 4'hF},
      '{4'd8,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'hF},
      '{4'd8,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'hF},
      '{4'd8,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'hF},
      '{4'd8,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 4'hD}, // R8 release request fires
      '{4'd2,  1'b1, 2'd0, 8'h00, 1'b0, 3'd0, 1'b0, 4'h0},
      '{4'd4,  1'b1, 2'd0, 8'h02, 1'b0, 3'd0, 1'b1, 4'h2},
      '{4'd2,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'h2},
      '{4'd2,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'h2},
      '{4'd2,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'h2},
      '{4'd2,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'h2},
      '{4'd2,  1'b0, 2'd0, 8'h00, 1'b0, 3'd0, 1'b1, 4'h2}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1ns;
   endtask

   task automatic idle_in();
      wr_en     = 1'b0;
      wr_addr   = '0;
      wr_data   = '0;
      usb_evt_i = 1'b0;
      gen_evt_i = '0;
   endtask

   task automatic write(input logic [1:0] a, input logic [7:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      tick();
      idle_in();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         done = 1'b1;
         finish_run();
      end
   end

   initial begin
      idle_in();
      repeat (3) @(posedge clk);
      #1ns rst_n = 1'b1;
      tick();

      // R1 reset state
      rd_addr = 2'd0; #1ns;
      chk("R1 ctrl", 32'(rd_data), 32'h0);
      rd_addr = 2'd1; #1ns;
      chk("R1 status", 32'(rd_data), 32'h0);
      rd_addr = 2'd2; #1ns;
      chk("R1 gen enable", 32'(rd_data), 32'h0);
      chk("R1 smi_n", 32'(smi_n_o), 32'h1);
      rd_addr = 2'd0;

      foreach (TBL[i]) begin
         wr_en     = TBL[i].wr;
         wr_addr   = TBL[i].wa;
         wr_data   = TBL[i].wd;
         usb_evt_i = TBL[i].usb;
         gen_evt_i = TBL[i].gen;
         tick();
         n_chk++;
         if ({smi_n_o, rd_data[3:0]} !== {TBL[i].smi, TBL[i].ctl}) begin
            n_fail++;
            $display("FAIL R%0d row %0d actual smi=%0b ctl=%0h expected smi=%0b ctl=%0h",
                     TBL[i].req, i, smi_n_o, rd_data[3:0], TBL[i].smi, TBL[i].ctl);
         end
      end
      idle_in();

      // R8 release write latched status bit 1 while its enable was off
      rd_addr = 2'd1; #1ns;
      chk("R8 status", 32'(rd_data), 32'h02);
      write(2'd1, 8'h02);
      chk("R10 clear", 32'(rd_data), 32'h00);

      // R10 set in the same cycle as clear wins
      usb_evt_i = 1'b1;
      write(2'd1, 8'h01);
      chk("R10 set wins", 32'(rd_data), 32'h01);
      write(2'd1, 8'h01);
      chk("R10 clear after", 32'(rd_data), 32'h00);

      // R9 generic enable readback
      write(2'd2, 8'h05);
      rd_addr = 2'd2; #1ns;
      chk("R9 gen enable", 32'(rd_data), 32'h05);

      // R6 no second assertion without end-of-service
      write(2'd0, 8'h09);
      usb_evt_i = 1'b1;
      tick();
      idle_in();
      tick();
      tick();
      chk("R6 no eos", 32'(smi_n_o), 32'h1);

      // R12 reset mid-run
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      rd_addr = 2'd0; #1ns;
      chk("R12 ctrl", 32'(rd_data), 32'h0);
      rd_addr = 2'd1; #1ns;
      chk("R12 status", 32'(rd_data), 32'h0);
      chk("R12 smi_n", 32'(smi_n_o), 32'h1);

      // R12 / R3 first-interrupt exception restored
      write(2'd0, 8'h09);
      usb_evt_i = 1'b1;
      tick();
      idle_in();
      chk("R3 one edge after event", 32'(smi_n_o), 32'h1);
      tick();
      chk("R12 first after reset", 32'(smi_n_o), 32'h0);

      done = 1'b1;
      finish_run();
   end

endmodule